// File: doc/BRIEF.md
# Buck Regulator Fault Supervisor

This block is the digital sequencing and protection core of a single-phase synchronous buck controller that also has a companion linear regulator. External comparators turn analog levels into flags: supply above lockout, soft-start above its arming and regulator-start levels, feedback under-voltage, over-voltage and below the crowbar release level, cycle current-limit trip, and junction hot and cool. The supervisor samples these flags once per switching period, using a clock enable. From them it decides when soft-start is released, when the modulator may switch, when the linear regulator may drive its pass gate, when the low-side switch must crowbar the output, and when the output is discharged.

Each fault needs its own persistence before it counts. An over-voltage must last two periods. An under-voltage or a run of current-limit trips must last sixteen. Any break in a run restarts its count. The latch for under-voltage, over-current and over-voltage is armed only after soft-start passes the arming level. The crowbar itself acts whenever the part is enabled and supplied. A latched fault stays set until enable is dropped or the supply is lost. In auto-restart mode it also clears by itself after a programmed number of periods. Over-temperature is handled apart from the latch and has its own release hysteresis.

Top module: `buck_fault_sup`

## Requirements
- R1: `ss_release` is 1 exactly when `supply_ok` and `enable` are both 1, no fault is latched and no over-temperature shutdown is held. `pwm_en` equals `ss_release` with the crowbar inactive.
- R2: While `ss_prot_ok` is 0, under-voltage and current-limit conditions never set `fault_latched`, however long they last.
- R3: `ldo_en` is 1 only when `ss_release` and `ss_ldo_ok` are both 1.
- R4: `fb_uv` sampled on UV_RUN consecutive ticks while armed sets `fault_latched` at the last of those ticks. UV_RUN defaults to 16, so 15 ticks leave it clear.
- R5: `skip_pulse` equals `pwm_en` and `ilim_trip` together. `ilim_trip` on OC_RUN consecutive armed ticks (default 16) sets `fault_latched`.
- R6: `fb_ov` on OV_RUN consecutive ticks (default 2) while enabled and supplied sets `crowbar` and forces `pwm_en` to 0. `crowbar` then holds until a tick samples `fb_low` at 1.
- R7: The crowbar acts before arming, and `fault_latched` stays 0 in that case. If the over-voltage run completes while armed, it also sets `fault_latched`.
- R8: While `fault_latched` is 1, `pwm_en` is 0. `crowbar` keeps following R6 independently.
- R9: A tick with `enable` at 0 or `supply_ok` at 0 clears `fault_latched`.
- R10: With `auto_restart` at 1, a latched fault clears by itself on the RESTART_TICKS-th tick of latched time.
- R11: A tick with `temp_hot` at 1 shuts the converter down. It restarts only after a tick with `temp_cool` at 1 and `temp_hot` at 0.
- R12: `discharge` is the complement of `pwm_en` at all times.
- R13: Any tick that breaks a persistence run, or on which the converter is not running, resets that run's count to zero.
- R14: State changes only on clock edges where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable per switching period |
| supply_ok | input | 1 | Supply above lockout |
| enable | input | 1 | Converter enable |
| ss_prot_ok | input | 1 | Soft-start above protection arming level |
| ss_ldo_ok | input | 1 | Soft-start above linear regulator start level |
| fb_uv | input | 1 | Feedback below under-voltage level |
| fb_ov | input | 1 | Feedback above over-voltage level |
| fb_low | input | 1 | Feedback below crowbar release level |
| ilim_trip | input | 1 | Cycle current-limit comparator tripped |
| temp_hot | input | 1 | Junction above shutdown temperature |
| temp_cool | input | 1 | Junction below release temperature |
| auto_restart | input | 1 | 1: timed auto-restart, 0: latch-off |
| ss_release | output | 1 | Release the soft-start ramp |
| pwm_en | output | 1 | Modulator may switch |
| ldo_en | output | 1 | Linear regulator gate drive enable |
| crowbar | output | 1 | Hold low-side switch on, high side off |
| discharge | output | 1 | Output discharge switch on |
| skip_pulse | output | 1 | Skip the current switching pulse |
| fault_latched | output | 1 | Fault latch state |

## Verification
Several properties are checked on every cycle. Switching requires supply and enable, and never happens under a latched fault. The linear regulator gate waits for its soft-start level. A latch can only rise after an armed tick. A crowbar cannot start without over-voltage, and it holds until the release level is seen. Fault and crowbar state do not move on edges where the enable is low. Run lengths are a different matter: that exactly 15 ticks do not trip and the 16th does, that a one-tick break restarts the count, the exact auto-restart delay, and the release of the over-temperature hysteresis can only be shown by the bench. It does this with directed scenarios and with a cycle-by-cycle reference model driven by random flags.

// File: rtl/buck_sup_pkg.sv
package buck_sup_pkg;

  // True when the current qualifying tick completes a run of len ticks,
  // given cnt earlier consecutive qualifying ticks.
  function automatic logic run_complete(input int unsigned cnt, input int unsigned len);
    return (cnt + 1) >= len;
  endfunction

  // Width needed to count 0..n-1, never below one bit.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/persist_run.sv
module persist_run #(
  parameter int unsigned RUN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic arm,
  input  logic cond,
  output logic hit
);
  import buck_sup_pkg::*;
  localparam int unsigned W = cnt_width(RUN);

  logic [W-1:0] cnt;
  logic         qual;

  assign qual = arm & cond;
  assign hit  = qual & run_complete(32'(cnt), RUN);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (tick) begin
      if (!qual)      cnt <= '0;
      else if (!hit)  cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/restart_timer.sv
module restart_timer #(
  parameter int unsigned TICKS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic active,
  output logic expire
);
  import buck_sup_pkg::*;
  localparam int unsigned W = cnt_width(TICKS);

  logic [W-1:0] cnt;

  assign expire = active & tick & run_complete(32'(cnt), TICKS);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (tick) begin
      if (!active || expire) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/overtemp_hold.sv
module overtemp_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hot,
  input  logic cool,
  output logic shut
);
  always_ff @(posedge clk) begin
    if (!rst_n)      shut <= 1'b0;
    else if (tick) begin
      if (hot)       shut <= 1'b1;
      else if (cool) shut <= 1'b0;
    end
  end
endmodule

// File: rtl/buck_fault_sup.sv
module buck_fault_sup #(
  parameter int unsigned UV_RUN        = 16,
  parameter int unsigned OC_RUN        = 16,
  parameter int unsigned OV_RUN        = 2,
  parameter int unsigned RESTART_TICKS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_ok,
  input  logic enable,
  input  logic ss_prot_ok,
  input  logic ss_ldo_ok,
  input  logic fb_uv,
  input  logic fb_ov,
  input  logic fb_low,
  input  logic ilim_trip,
  input  logic temp_hot,
  input  logic temp_cool,
  input  logic auto_restart,
  output logic ss_release,
  output logic pwm_en,
  output logic ldo_en,
  output logic crowbar,
  output logic discharge,
  output logic skip_pulse,
  output logic fault_latched
);
  // named internal events
  logic live, run, armed;
  logic uv_hit, oc_hit, ov_hit, fault_set, restart_due;
  logic fault_q, cb_q, ot_shut;

  assign live      = supply_ok & enable;
  assign run       = live & ~fault_q & ~ot_shut;
  assign armed     = run & ss_prot_ok;
  assign fault_set = armed & (uv_hit | oc_hit | ov_hit);

  persist_run #(.RUN(UV_RUN)) u_uv_run (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(armed), .cond(fb_uv), .hit(uv_hit));

  persist_run #(.RUN(OC_RUN)) u_oc_run (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(armed), .cond(ilim_trip), .hit(oc_hit));

  persist_run #(.RUN(OV_RUN)) u_ov_run (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(live), .cond(fb_ov), .hit(ov_hit));

  restart_timer #(.TICKS(RESTART_TICKS)) u_restart (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .active(fault_q & auto_restart), .expire(restart_due));

  overtemp_hold u_ot (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .hot(temp_hot), .cool(temp_cool), .shut(ot_shut));

  always_ff @(posedge clk) begin
    if (!rst_n)          fault_q <= 1'b0;
    else if (tick) begin
      if (!live)         fault_q <= 1'b0;
      else if (restart_due) fault_q <= 1'b0;
      else if (fault_set) fault_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cb_q <= 1'b0;
    else if (tick) begin
      if (!live)       cb_q <= 1'b0;
      else if (ov_hit) cb_q <= 1'b1;
      else if (fb_low) cb_q <= 1'b0;
    end
  end

  assign ss_release    = run;
  assign pwm_en        = run & ~cb_q;
  assign ldo_en        = run & ss_ldo_ok;
  assign crowbar       = cb_q;
  assign discharge     = ~pwm_en;
  assign skip_pulse    = pwm_en & ilim_trip;
  assign fault_latched = fault_q;
endmodule

// File: rtl/buck_fault_sup_chk.sv
module buck_fault_sup_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic supply_ok,
  input logic enable,
  input logic ss_prot_ok,
  input logic ss_ldo_ok,
  input logic fb_ov,
  input logic fb_low,
  input logic ss_release,
  input logic pwm_en,
  input logic ldo_en,
  input logic crowbar,
  input logic fault_latched
);
  AST_PWM_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en |-> (supply_ok && enable && ss_release)); // R1

  AST_LDO_WAITS_SS: assert property (@(posedge clk) disable iff (!rst_n)
    ldo_en |-> (ss_ldo_ok && ss_release)); // R3

  AST_LATCH_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_latched) |-> $past(tick && ss_prot_ok)); // R2

  AST_CROWBAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crowbar) |-> $past(fb_ov && enable && supply_ok)); // R6

  AST_CROWBAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && crowbar && !fb_low && enable && supply_ok) |=> crowbar); // R6

  AST_NO_SWITCH_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> !pwm_en); // R8

  AST_QUIET_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(fault_latched) && $stable(crowbar))); // R14
endmodule

bind buck_fault_sup buck_fault_sup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok), .enable(enable),
  .ss_prot_ok(ss_prot_ok), .ss_ldo_ok(ss_ldo_ok), .fb_ov(fb_ov), .fb_low(fb_low),
  .ss_release(ss_release), .pwm_en(pwm_en), .ldo_en(ldo_en), .crowbar(crowbar),
  .fault_latched(fault_latched));

// File: tb/tb_buck_fault_sup.sv
`timescale 1ns/1ps
module tb_buck_fault_sup;
  localparam int UV = 16, OC = 16, OV = 2, RST = 24;

  logic clk = 0, rst_n = 0, tick = 0, tick_hold = 0;
  logic supply_ok = 0, enable = 0, ss_prot_ok = 0, ss_ldo_ok = 0;
  logic fb_uv = 0, fb_ov = 0, fb_low = 0, ilim_trip = 0;
  logic temp_hot = 0, temp_cool = 0, auto_restart = 0;
  logic ss_release, pwm_en, ldo_en, crowbar, discharge, skip_pulse, fault_latched;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  buck_fault_sup #(.UV_RUN(UV), .OC_RUN(OC), .OV_RUN(OV), .RESTART_TICKS(RST)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok), .enable(enable),
    .ss_prot_ok(ss_prot_ok), .ss_ldo_ok(ss_ldo_ok), .fb_uv(fb_uv), .fb_ov(fb_ov),
    .fb_low(fb_low), .ilim_trip(ilim_trip), .temp_hot(temp_hot), .temp_cool(temp_cool),
    .auto_restart(auto_restart), .ss_release(ss_release), .pwm_en(pwm_en),
    .ldo_en(ldo_en), .crowbar(crowbar), .discharge(discharge), .skip_pulse(skip_pulse),
    .fault_latched(fault_latched));

  // tick every other clock unless held
  always @(negedge clk) tick <= tick_hold ? 1'b0 : ~tick;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model state
  int m_uv = 0, m_oc = 0, m_ov = 0, m_rt = 0;
  bit m_fault = 0, m_cb = 0, m_ot = 0;

  always @(posedge clk) begin
    bit live, run, armed, uvh, och, ovh, expd;
    if (!rst_n) begin
      m_uv = 0; m_oc = 0; m_ov = 0; m_rt = 0; m_fault = 0; m_cb = 0; m_ot = 0;
    end else if (tick) begin
      live  = supply_ok && enable;
      run   = live && !m_fault && !m_ot;
      armed = run && ss_prot_ok;
      m_uv  = (armed && fb_uv) ? m_uv + 1 : 0;      uvh = (m_uv >= UV);
      m_oc  = (armed && ilim_trip) ? m_oc + 1 : 0;  och = (m_oc >= OC);
      m_ov  = (live && fb_ov) ? m_ov + 1 : 0;       ovh = (m_ov >= OV);
      expd  = 0;
      if (m_fault && auto_restart) begin
        m_rt++;
        if (m_rt >= RST) begin expd = 1; m_rt = 0; end
      end else m_rt = 0;
      if (!live)      m_fault = 0;
      else if (expd)  m_fault = 0;
      else if (armed && (uvh || och || ovh)) m_fault = 1;
      if (!live)      m_cb = 0;
      else if (ovh)   m_cb = 1;
      else if (fb_low) m_cb = 0;
      if (temp_hot)   m_ot = 1;
      else if (temp_cool) m_ot = 0;
    end
    #2;
    if (rst_n && !done) begin
      bit e_run, e_pwm;
      e_run = supply_ok && enable && !m_fault && !m_ot;
      e_pwm = e_run && !m_cb;
      chk("R1",  "ss_release",    ss_release,    e_run);
      chk("R1",  "pwm_en",        pwm_en,        e_pwm);
      chk("R3",  "ldo_en",        ldo_en,        e_run && ss_ldo_ok);
      chk("R6",  "crowbar",       crowbar,       m_cb);
      chk("R12", "discharge",     discharge,     !e_pwm);
      chk("R5",  "skip_pulse",    skip_pulse,    e_pwm && ilim_trip);
      chk("R4",  "fault_latched", fault_latched, m_fault);
    end
  end

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    #3;
  endtask

  task automatic clear_fault();
    @(negedge clk); enable = 0;
    wait_ticks(1);
    @(negedge clk); enable = 1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    wait_ticks(1);
    chk("R1",  "reset pwm_en", pwm_en, 1'b0);
    chk("R12", "reset discharge", discharge, 1'b1);
    chk("R4",  "reset fault", fault_latched, 1'b0);

    // power up
    @(negedge clk); supply_ok = 1; enable = 1;
    wait_ticks(1);
    chk("R1", "startup pwm_en", pwm_en, 1'b1);
    chk("R3", "ldo before level", ldo_en, 1'b0);

    // R2: under-voltage ignored before arming
    @(negedge clk); fb_uv = 1;
    wait_ticks(20);
    chk("R2", "uv unarmed fault", fault_latched, 1'b0);
    @(negedge clk); ss_prot_ok = 1; ss_ldo_ok = 1;
    wait_ticks(15);
    chk("R3", "ldo after level", ldo_en, 1'b1);
    chk("R4", "uv 15 ticks", fault_latched, 1'b0);
    wait_ticks(1);
    chk("R4", "uv 16 ticks", fault_latched, 1'b1);
    chk("R12", "discharge in fault", discharge, 1'b1);
    @(negedge clk); fb_uv = 0;
    clear_fault();
    wait_ticks(1);
    chk("R9", "enable toggle clears", fault_latched, 1'b0);

    // R13: break restarts the run
    @(negedge clk); fb_uv = 1; wait_ticks(10);
    @(negedge clk); fb_uv = 0; wait_ticks(1);
    @(negedge clk); fb_uv = 1; wait_ticks(15);
    chk("R13", "run after break", fault_latched, 1'b0);
    wait_ticks(1);
    chk("R13", "full run after break", fault_latched, 1'b1);
    @(negedge clk); fb_uv = 0;
    clear_fault();

    // R5: current limit
    @(negedge clk); ilim_trip = 1; #1;
    chk("R5", "skip pulse", skip_pulse, 1'b1);
    wait_ticks(15);
    chk("R5", "oc 15 ticks", fault_latched, 1'b0);
    wait_ticks(1);
    chk("R5", "oc 16 ticks", fault_latched, 1'b1);
    chk("R5", "no skip in fault", skip_pulse, 1'b0);
    @(negedge clk); ilim_trip = 0;
    clear_fault();

    // R6/R7: crowbar before arming
    @(negedge clk); ss_prot_ok = 0; ss_ldo_ok = 0; fb_ov = 1;
    wait_ticks(1);
    chk("R6", "ov one tick", crowbar, 1'b0);
    wait_ticks(1);
    chk("R6", "ov two ticks", crowbar, 1'b1);
    chk("R6", "pwm off in crowbar", pwm_en, 1'b0);
    chk("R7", "no latch unarmed", fault_latched, 1'b0);
    @(negedge clk); fb_ov = 0;
    wait_ticks(3);
    chk("R6", "crowbar hysteresis", crowbar, 1'b1);
    @(negedge clk); fb_low = 1;
    wait_ticks(1);
    chk("R6", "crowbar release", crowbar, 1'b0);
    chk("R1", "pwm after release", pwm_en, 1'b1);

    // R7/R8: armed over-voltage latches
    @(negedge clk); fb_low = 0; ss_prot_ok = 1; fb_ov = 1;
    wait_ticks(2);
    chk("R7", "armed ov latch", fault_latched, 1'b1);
    chk("R8", "crowbar in fault", crowbar, 1'b1);
    @(negedge clk); fb_ov = 0; fb_low = 1;
    wait_ticks(1);
    chk("R8", "crowbar released in fault", crowbar, 1'b0);
    chk("R8", "fault holds", fault_latched, 1'b1);

    // R10: auto restart
    @(negedge clk); fb_low = 0; auto_restart = 1;
    wait_ticks(RST - 1);
    chk("R10", "before restart", fault_latched, 1'b1);
    wait_ticks(1);
    chk("R10", "auto restart", fault_latched, 1'b0);
    @(negedge clk); auto_restart = 0;

    // R11: over-temperature hysteresis
    @(negedge clk); temp_hot = 1; wait_ticks(1);
    chk("R11", "hot shutdown", pwm_en, 1'b0);
    @(negedge clk); temp_hot = 0; wait_ticks(3);
    chk("R11", "hold until cool", pwm_en, 1'b0);
    @(negedge clk); temp_cool = 1; wait_ticks(1);
    chk("R11", "cool restart", pwm_en, 1'b1);
    @(negedge clk); temp_cool = 0;

    // R9: supply loss clears
    @(negedge clk); ilim_trip = 1; wait_ticks(16);
    chk("R9", "fault before supply loss", fault_latched, 1'b1);
    @(negedge clk); ilim_trip = 0; supply_ok = 0; wait_ticks(1);
    @(negedge clk); supply_ok = 1; wait_ticks(1);
    chk("R9", "supply cycle clears", fault_latched, 1'b0);

    // R14: nothing moves without tick
    @(negedge clk); tick_hold = 1;
    @(negedge clk); temp_hot = 1;
    repeat (6) @(negedge clk);
    chk("R14", "no tick no shutdown", pwm_en, 1'b1);
    temp_hot = 0; tick_hold = 0;
    wait_ticks(2);

    // random flags against the model
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      supply_ok    = ($urandom % 40) != 0;
      enable       = ($urandom % 30) != 0;
      ss_prot_ok   = ($urandom % 5) != 0;
      ss_ldo_ok    = ($urandom % 3) != 0;
      fb_uv        = ($urandom % 8) != 0;
      fb_ov        = ($urandom % 4) == 0;
      fb_low       = ($urandom % 4) == 0;
      ilim_trip    = ($urandom % 6) != 0;
      temp_hot     = ($urandom % 60) == 0;
      temp_cool    = ($urandom % 5) == 0;
      auto_restart = ($urandom % 2) == 0;
    end
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule